// File: doc/BRIEF.md
# Grouped Level-Interrupt Combiner

This block merges a large set of level-sensitive interrupt sources into a small number of parent interrupt lines. The sources are split into groups of eight, and each group drives one parent line. Source number `s` belongs to group `s/8` at position `s%8`, and it appears on input bit `src_in[s]`. A parent line is high while at least one enabled source of its group is high.

Four consecutive groups share one 32-bit register bank, and each group owns one byte lane of it. Software turns sources on by writing ones to a set address. It turns them off by writing ones to a clear address. Zero bits in either write change nothing. Software can read back the enable word, and it can read a status word that shows which enabled sources are asserting. The block stores no edges. A source counts as pending only while its input is high.

Top module: `intc_group_combiner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every enable bit, every `grp_irq` bit and `rdata` are zero.
- R2: A write to byte address `b*0x10 + 0x0` sets enable bit `s = b*32 + i` for every bit `i` of `wdata` that is 1. Bits that are 0 leave their enables unchanged. Group `g` therefore uses lane `g%4`, bits `[8*(g%4)+7 : 8*(g%4)]` of bank `g/4`.
- R3: A write to byte address `b*0x10 + 0x4` clears enable bit `b*32 + i` for every 1 in `wdata`. Bits that are 0 leave their enables unchanged.
- R4: A read of offset 0x0 of a bank returns that bank's 32 enable bits. Writing that value back to the set address after a full clear restores the same enables.
- R5: A read of offset 0xC of bank `b` returns bit `i` = `src_in[b*32+i] AND enable[b*32+i]`, taken in the cycle of the read request.
- R6: `grp_irq[g]` is the OR over `src_in[8g+k] AND enable[8g+k]`, for k = 0..7. It is registered, so it follows its inputs with one clock of latency.
- R7: The inputs are level-sensitive. Once a source's input falls, its group line and its status bit drop as soon as their latency allows. No pending state is kept.
- R8: Any other address reads as zero, and writes to it change no enable. This covers offset 0x8, writes to 0xC, addresses with nonzero bits [1:0], and banks numbered `NUM_GROUPS/4` rounded up or higher.
- R9: `rdata` is registered. It carries the addressed word in the cycle after `rd_en` is high, and it is zero in the cycle after `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (7) | Byte address: bank in bits [ADDR_W-1:4], register in bits [3:0] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_in | input | NUM_GROUPS*8 (160) | Level interrupt sources, source s on bit s |
| grp_irq | output | NUM_GROUPS (20) | One registered parent interrupt per group |

## Verification
An enable write takes effect at the clock edge that samples it, so a read-back issued right after the write shows the new value. The group line reflects that change one edge later. A read returns data one edge after the request, and a change on a source shows on its group line one edge after the change. The bench drives every stimulus on a falling edge and samples on the falling edge that follows the register stage. It also waits one more falling edge before it compares `grp_irq` after any enable or source change. The reference enables and sources are not changed while a read or a group check is pending.

// File: rtl/intc_comb_pkg.sv
package intc_comb_pkg;
  localparam int LINES_PER_GROUP = 8;
  localparam int GROUPS_PER_BANK = 4;
  localparam int WORD_W          = LINES_PER_GROUP * GROUPS_PER_BANK;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_STAT = 2'd3
  } reg_kind_t;
endpackage

// File: rtl/intc_comb_regdec.sv
module intc_comb_regdec
  import intc_comb_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 3,
  parameter int ADDR_W    = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output reg_kind_t         kind
);
  logic bank_ok;

  assign bank    = addr[ADDR_W-1:4];
  assign bank_ok = int'(bank) < NUM_BANKS;

  always_comb begin
    kind = REG_NONE;
    if (bank_ok) begin
      case (addr[3:0])
        4'h0:    kind = REG_SET;
        4'h4:    kind = REG_CLR;
        4'hC:    kind = REG_STAT;
        default: kind = REG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/intc_comb_enables.sv
module intc_comb_enables
  import intc_comb_pkg::*;
#(
  parameter int NUM_SRC   = 160,
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [BANK_W-1:0]             bank,
  input  reg_kind_t                     kind,
  input  logic [WORD_W-1:0]             wdata,
  output logic [NUM_BANKS*WORD_W-1:0]   en_all
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int VCNT = ((NUM_SRC - b*WORD_W) >= WORD_W) ? WORD_W : (NUM_SRC - b*WORD_W);
    localparam logic [WORD_W-1:0] MASK =
      (VCNT == WORD_W) ? {WORD_W{1'b1}} : ((WORD_W'(1) << VCNT) - WORD_W'(1));

    logic [WORD_W-1:0] en_q;
    logic              sel;

    assign sel = wr_en && (int'(bank) == b);

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q <= '0;
      end else if (sel && kind == REG_SET) begin
        en_q <= en_q | (wdata & MASK);
      end else if (sel && kind == REG_CLR) begin
        en_q <= en_q & ~wdata;
      end
    end

    assign en_all[b*WORD_W +: WORD_W] = en_q;
  end
endmodule

// File: rtl/intc_comb_group_or.sv
module intc_comb_group_or
  import intc_comb_pkg::*;
#(
  parameter int NUM_GROUPS = 20
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] src_in,
  input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] en_src,
  output logic [NUM_GROUPS-1:0]                 grp_irq
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = |(src_in[g*LINES_PER_GROUP +: LINES_PER_GROUP] &
                   en_src[g*LINES_PER_GROUP +: LINES_PER_GROUP]);
    always_ff @(posedge clk) begin
      if (rst) grp_irq[g] <= 1'b0;
      else     grp_irq[g] <= hit;
    end
  end
endmodule

// File: rtl/intc_group_combiner.sv
module intc_group_combiner
  import intc_comb_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  localparam int NUM_SRC   = NUM_GROUPS * LINES_PER_GROUP,
  localparam int NUM_BANKS = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = BANK_W + 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     rdata,
  input  logic [NUM_SRC-1:0]    src_in,
  output logic [NUM_GROUPS-1:0] grp_irq
);
  localparam int PAD_W = NUM_BANKS * WORD_W;

  logic [BANK_W-1:0] bank;
  reg_kind_t         kind;
  logic [PAD_W-1:0]  en_all;
  logic [PAD_W-1:0]  src_pad;

  intc_comb_regdec #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(addr), .bank(bank), .kind(kind)
  );

  intc_comb_enables #(
    .NUM_SRC(NUM_SRC), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) u_en (
    .clk(clk), .rst(rst), .wr_en(wr_en), .bank(bank), .kind(kind),
    .wdata(wdata), .en_all(en_all)
  );

  intc_comb_group_or #(
    .NUM_GROUPS(NUM_GROUPS)
  ) u_or (
    .clk(clk), .rst(rst), .src_in(src_in), .en_src(en_all[NUM_SRC-1:0]),
    .grp_irq(grp_irq)
  );

  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = src_in;
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      rdata <= '0;
    end else begin
      case (kind)
        REG_SET:  rdata <= en_all[bank*WORD_W +: WORD_W];
        REG_STAT: rdata <= en_all[bank*WORD_W +: WORD_W] & src_pad[bank*WORD_W +: WORD_W];
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_group_combiner_chk.sv
module intc_group_combiner_chk #(
  parameter int NUM_GROUPS = 20,
  parameter int PAD_W      = 160,
  parameter int ADDR_W     = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [31:0]           rdata,
  input logic [NUM_GROUPS-1:0] grp_irq,
  input logic [PAD_W-1:0]      src_pad,
  input logic [PAD_W-1:0]      en_all
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_all == '0 && grp_irq == '0 && rdata == '0));

  // R2
  set_only_grows_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(addr[3:0]) == 4'h0) |-> ((en_all & $past(en_all)) == $past(en_all)));

  // R3
  clear_only_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(addr[3:0]) == 4'h4) |-> ((en_all & ~$past(en_all)) == '0));

  // R8
  no_write_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) || ($past(addr[3:0]) != 4'h0 && $past(addr[3:0]) != 4'h4)) |-> $stable(en_all));

  // R6
  grp_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_irq != '0) |-> $past(|(src_pad & en_all)));

  // R6
  source_raises_grp_chk: assert property (@(posedge clk) disable iff (rst)
    $past(|(src_pad & en_all)) |-> (grp_irq != '0));

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> (rdata == '0));
endmodule

bind intc_group_combiner intc_group_combiner_chk #(
  .NUM_GROUPS(NUM_GROUPS), .PAD_W(PAD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .grp_irq(grp_irq), .src_pad(src_pad), .en_all(en_all)
);

// File: tb/intc_group_combiner_test.sv
module intc_group_combiner_test;
  localparam int NG   = 20;
  localparam int NSRC = NG * 8;
  localparam int NB   = 5;
  localparam int AW   = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   addr  = '0;
  logic [31:0]     wdata = '0;
  logic [NSRC-1:0] src   = '0;
  logic [31:0]     rdata;
  logic [NG-1:0]   grp_irq;

  logic [NSRC-1:0] m_en = '0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  intc_group_combiner #(.NUM_GROUPS(NG)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_in(src), .grp_irq(grp_irq)
  );

  function automatic logic [31:0] exp_word(bit status, int b);
    logic [31:0] w = '0;
    if (b < NB) begin
      for (int i = 0; i < 32; i++) begin
        int idx = b * 32 + i;
        if (idx < NSRC) w[i] = status ? (m_en[idx] & src[idx]) : m_en[idx];
      end
    end
    return w;
  endfunction

  function automatic logic [NG-1:0] exp_grp();
    logic [NG-1:0] g = '0;
    for (int k = 0; k < NSRC; k++) if (m_en[k] && src[k]) g[k/8] = 1'b1;
    return g;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [31:0] d);
    int b, off;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    b = int'(a) >> 4; off = int'(a) & 15;
    if (b < NB) begin
      for (int i = 0; i < 32; i++) begin
        int idx = b * 32 + i;
        if (idx < NSRC && d[i]) begin
          if (off == 0) m_en[idx] = 1'b1;
          if (off == 4) m_en[idx] = 1'b0;
        end
      end
    end
  endtask

  task automatic do_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic check_grp(string req);
    @(negedge clk);
    chk(req, 32'(grp_irq), 32'(exp_grp()));
  endtask

  task automatic set_src(logic [NSRC-1:0] v, string req);
    @(negedge clk);
    src = v;
    check_grp(req);
  endtask

  function automatic logic [NSRC-1:0] rnd_src();
    logic [NSRC-1:0] v;
    for (int i = 0; i < NSRC; i += 32) v[i +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] saved [NB];
    void'($urandom(32'd7321));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 grp", 32'(grp_irq), 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    for (int b = 0; b < NB; b++) begin
      do_read(AW'(b * 16), r);
      chk("R1 enables", r, 32'h0);
    end
    set_src('1, "R1 grp with all sources high");

    // R2: set lane of group 0 and group 5 (bank 1 lane 1)
    do_write(7'h00, 32'h0000_00FF);
    do_write(7'h10, 32'h0000_0100);
    check_grp("R2 groups 0 and 5");
    do_read(7'h00, r); chk("R2 bank0 readback", r, 32'h0000_00FF);
    do_read(7'h10, r); chk("R2 bank1 readback", r, 32'h0000_0100);
    do_write(7'h00, 32'h0);
    do_read(7'h00, r); chk("R2 zero write no effect", r, 32'h0000_00FF);

    // R3: clear
    do_write(7'h04, 32'h0000_000F);
    do_read(7'h00, r); chk("R3 partial clear", r, 32'h0000_00F0);
    do_write(7'h04, 32'h0);
    do_read(7'h00, r); chk("R3 zero clear no effect", r, 32'h0000_00F0);
    do_write(7'h14, 32'h0000_0100);
    check_grp("R3 group 5 off");

    // R8: unmapped addresses
    do_write(7'h08, 32'hFFFF_FFFF);
    do_write(7'h0C, 32'hFFFF_FFFF);
    do_write(7'h01, 32'hFFFF_FFFF);
    do_write(7'h50, 32'hFFFF_FFFF);
    do_write(7'h74, 32'hFFFF_FFFF);
    do_read(7'h00, r); chk("R8 bank0 unchanged", r, 32'h0000_00F0);
    do_read(7'h10, r); chk("R8 bank1 unchanged", r, 32'h0);
    do_read(7'h08, r); chk("R8 read 0x8", r, 32'h0);
    do_read(7'h50, r); chk("R8 read bank5", r, 32'h0);
    do_read(7'h5C, r); chk("R8 read bank5 status", r, 32'h0);
    check_grp("R8 groups unchanged");

    // R9: idle rdata
    @(negedge clk);
    chk("R9 idle rdata", rdata, 32'h0);

    // R7 / R5: level behaviour
    do_write(7'h40, 32'hFFFF_FFFF);
    set_src('0, "R7 all low");
    do_read(7'h4C, r); chk("R7 status low", r, 32'h0);
    set_src(NSRC'(1) << 150, "R7 single source high");
    do_read(7'h4C, r); chk("R5 status single", r, exp_word(1'b1, 4));
    set_src('0, "R7 source released");
    do_read(7'h4C, r); chk("R7 status released", r, 32'h0);

    // R5/R6: random enables and sources
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 4;
      int b  = $urandom % 6;
      int o  = ($urandom % 4) * 4;
      logic [AW-1:0] a = AW'(b * 16 + o);
      case (op)
        0: begin do_write(AW'(b * 16), $urandom); check_grp("R2 random set"); end
        1: begin do_write(AW'(b * 16 + 4), $urandom); check_grp("R3 random clear"); end
        2: set_src(rnd_src(), "R6 random sources");
        default: begin
          do_read(a, r);
          if (b < NB && o == 0)       chk("R4 random enable read", r, exp_word(1'b0, b));
          else if (b < NB && o == 12) chk("R5 random status", r, exp_word(1'b1, b));
          else                        chk("R8 random unmapped read", r, 32'h0);
        end
      endcase
    end

    // R4: save, clear all, restore
    for (int b = 0; b < NB; b++) begin
      do_read(AW'(b * 16), r); saved[b] = r;
      chk("R4 save", r, exp_word(1'b0, b));
    end
    for (int b = 0; b < NB; b++) do_write(AW'(b * 16 + 4), 32'hFFFF_FFFF);
    check_grp("R4 all cleared");
    for (int b = 0; b < NB; b++) do_write(AW'(b * 16), saved[b]);
    for (int b = 0; b < NB; b++) begin
      do_read(AW'(b * 16), r);
      chk("R4 restore", r, saved[b]);
    end
    check_grp("R4 groups after restore");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule